// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider

This block divides a stream of count events by a power of two chosen by a small program code. A binary code N selects a division of 2^N on the main output `q`, which is a 50%-duty square wave. A second output, `tap`, gives a fixed auxiliary ratio. That ratio depends on the code only in a few code bands. It lets a test step through a divided waveform far faster than `q` would at large N.

Count events come from two clock-like inputs, `clkA` and `clkB`, which are sampled as levels in the system clock domain. A rise on one of them counts only while the other is low, so a high level on either input stops the count. An active-low clear forces everything low at once. Its release is synchronised to `clk`. A new program code takes effect on the next counted event, which restarts the output from its low phase. The width of the program code is a parameter. The default of 5 bits covers ratios up to 2^31, and a 4-bit build covers ratios up to 2^15 with its own tap rule.

Top module: `pow2_divider`

## Requirements
- R1: While `clearN` is low, `q` and `tap` are low, with no wait for a `clk` edge and whatever the clock inputs do. After release the loaded code reads as 0 until the next counted event.
- R2: A counted event is a cycle in which `clkA` is high after being low in the previous cycle while `clkB` is low, or `clkB` is high after being low while `clkA` is low. After a clear, an input must first be seen low before its rise counts. Each counted event advances the count by exactly one.
- R3: A rise on one input while the other is high does not count. Neither does a simultaneous rise of both, nor a level held high. `q` and `tap` keep their values through all of these.
- R4: With loaded code 0 or 1, `q` and `tap` stay low whatever events arrive.
- R5: With loaded code N from 2 to 2^CODE_W-1, `q` rises on the 2^(N-1)-th counted event after the load and falls on the 2^N-th, repeating with a period of 2^N events.
- R6: In the 5-bit build, for codes 2 to 21, 30 and 31, `tap` rises on the 256th counted event after the load and falls on the 512th (ratio 512).
- R7: In the 5-bit build, codes 22 and 23 hold `tap` low.
- R8: In the 5-bit build, codes 24 and 25 give `tap` a ratio of 8, codes 26 and 27 a ratio of 32, and codes 28 and 29 a ratio of 128. In each case the rise comes at half the ratio.
- R9: A value on `progCode` that differs from the loaded code has no effect until the next counted event. That event loads the new code and clears the count instead of advancing it, so `q` and `tap` are low right after it.
- R10: In the 4-bit build, `tap` is low for codes 0, 1 and 7. It has ratio 2^(N-6) for codes 8 to 15 and ratio 512 for codes 2 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clearN | input | 1 | Active-low clear; asserted asynchronously, released synchronously |
| clkA | input | 1 | First count input, sampled as a level |
| clkB | input | 1 | Second count input, sampled as a level |
| progCode | input | CODE_W | Program code N selecting the ratio 2^N |
| q | output | 1 | Divided square-wave output |
| tap | output | 1 | Auxiliary divided output with its code-band ratio |

## Verification
A counted event seen in a cycle changes the count at the end of that cycle. `q` and `tap` are decoded straight from the count and the loaded code, so both show the new value one `clk` edge after the inputs are driven. A clear acts on the outputs at once, with no clock needed. The bench drives `clkA`, `clkB` and `progCode` on the falling edge and samples the outputs on the next falling edge. Each sample therefore sees exactly one edge's worth of change. For the clear, it samples one nanosecond after pulling `clearN` low, before any rising edge. Ratios are measured by counting events from the load until the first rise and the following fall of each output.

// File: rtl/pow2_divider_pkg.sv
package pow2_divider_pkg;

  // Strobes from control to datapath, at most one active per cycle.
  typedef struct packed {
    logic advance;   // add one to the count
    logic restart;   // clear the count and load a new code
  } stepStrobeT;

  // Counter bit that drives the auxiliary output for a given code, or -1
  // when the output is held low. Bit k of a binary count divides by 2^(k+1).
  function automatic int tapIndex(int codeW, int code);
    if (code < 2) return -1;
    if (codeW == 4) begin
      if (code == 7) return -1;
      if (code >= 8) return code - 7;
      return 8;
    end
    if (code == 22 || code == 23) return -1;
    if (code >= 24 && code <= 29) return 2 + 2 * ((code - 24) / 2);
    return 8;
  endfunction

endpackage

// File: rtl/pow2_divider_ctrl.sv
module pow2_divider_ctrl
  import pow2_divider_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              clkA,
  input  logic              clkB,
  input  logic [CODE_W-1:0] progCode,
  output logic              syncN,
  output stepStrobeT        strb,
  output logic [CODE_W-1:0] activeCode
);

  localparam logic [CODE_W-1:0] MIN_ACTIVE = CODE_W'(2);

  logic [1:0] clrPipe;
  logic       aPrev;
  logic       bPrev;
  logic       riseA;
  logic       riseB;
  logic       qualEdge;
  logic       codeDiff;

  // Clear: immediate on assertion, two-stage release into the clk domain.
  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) clrPipe <= 2'b00;
    else         clrPipe <= {clrPipe[0], 1'b1};
  end
  assign syncN = clrPipe[1];

  // Previous levels reset high so that an input held high is not a rise.
  always_ff @(posedge clk or negedge syncN) begin
    if (!syncN) begin
      aPrev      <= 1'b1;
      bPrev      <= 1'b1;
      activeCode <= '0;
    end else begin
      aPrev <= clkA;
      bPrev <= clkB;
      if (strb.restart) activeCode <= progCode;
    end
  end

  always_comb begin
    riseA    = clkA && !aPrev;
    riseB    = clkB && !bPrev;
    qualEdge = syncN && ((riseA && !clkB) || (riseB && !clkA));
    codeDiff = (progCode != activeCode);
    strb.restart = qualEdge && codeDiff;
    strb.advance = qualEdge && !codeDiff && (activeCode >= MIN_ACTIVE);
  end

  AST_LEVEL_INHIBIT: assert property (@(posedge clk) disable iff (!syncN)
    (clkA && clkB) |-> !(strb.advance || strb.restart)); // R3

  AST_CODE_LOADED: assert property (@(posedge clk) disable iff (!syncN)
    $past(strb.restart) |-> (activeCode == $past(progCode))); // R9

endmodule

// File: rtl/pow2_divider_dp.sv
module pow2_divider_dp
  import pow2_divider_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobeT        strb,
  input  logic [CODE_W-1:0] activeCode,
  output logic              q,
  output logic              tap
);

  localparam int NUM_CODES = 1 << CODE_W;
  localparam int CNT_W     = NUM_CODES - 1;
  localparam logic [CODE_W-1:0] MIN_ACTIVE = CODE_W'(2);

  logic [CNT_W-1:0]     cnt;
  logic [NUM_CODES-1:0] qVec;
  logic [NUM_CODES-1:0] tapVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.restart) cnt <= '0;
    else if (strb.advance) cnt <= cnt + 1'b1;
  end

  // One candidate per code; the loaded code picks one of each.
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_sel
    localparam int TI = tapIndex(CODE_W, c);
    if (c >= 2) begin : g_q
      assign qVec[c] = cnt[c-1];
    end else begin : g_qlow
      assign qVec[c] = 1'b0;
    end
    if (TI >= 0) begin : g_tap
      assign tapVec[c] = cnt[TI];
    end else begin : g_taplow
      assign tapVec[c] = 1'b0;
    end
  end

  assign q   = qVec[activeCode];
  assign tap = tapVec[activeCode];

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.advance) && !$past(strb.restart)) |-> ($stable(q) && $stable(tap))); // R3

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.restart) |-> (!q && !tap)); // R9

  AST_INHIBIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode < MIN_ACTIVE) |-> (!q && !tap)); // R4

endmodule

// File: rtl/pow2_divider.sv
module pow2_divider
  import pow2_divider_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              clkA,
  input  logic              clkB,
  input  logic [CODE_W-1:0] progCode,
  output logic              q,
  output logic              tap
);

  logic              syncN;
  stepStrobeT        strb;
  logic [CODE_W-1:0] activeCode;

  pow2_divider_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .clearN     (clearN),
    .clkA       (clkA),
    .clkB       (clkB),
    .progCode   (progCode),
    .syncN      (syncN),
    .strb       (strb),
    .activeCode (activeCode)
  );

  pow2_divider_dp #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (syncN),
    .strb       (strb),
    .activeCode (activeCode),
    .q          (q),
    .tap        (tap)
  );

endmodule

// File: tb/pow2_divider_test.sv
`timescale 1ns/1ps
module pow2_divider_test;

  logic clk = 1'b0;
  logic clearN = 1'b0;
  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic [4:0] prog5 = '0;
  logic [3:0] prog4 = '0;
  logic q5, t5, q4, t4;
  int total = 0;
  int bad = 0;
  bit nextA = 1'b1;

  always #2.5 clk = ~clk;

  pow2_divider #(.CODE_W(5)) uut (
    .clk(clk), .clearN(clearN), .clkA(clkA), .clkB(clkB),
    .progCode(prog5), .q(q5), .tap(t5));

  pow2_divider #(.CODE_W(4)) uutSmall (
    .clk(clk), .clearN(clearN), .clkA(clkA), .clkB(clkB),
    .progCode(prog4), .q(q4), .tap(t4));

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected ratios; 0 means the output is held low.
  function automatic longint ratioQ(int n);
    return (n < 2) ? 0 : (64'(1) << n);
  endfunction

  function automatic longint ratioT5(int n);
    if (n < 2 || n == 22 || n == 23) return 0;
    if (n == 24 || n == 25) return 8;
    if (n == 26 || n == 27) return 32;
    if (n == 28 || n == 29) return 128;
    return 512;
  endfunction

  function automatic longint ratioT4(int n);
    if (n < 2 || n == 7) return 0;
    if (n >= 8) return 64'(1) << (n - 6);
    return 512;
  endfunction

  function automatic string tagT5(int n);
    if (n < 2) return "R4";
    if (n == 22 || n == 23) return "R7";
    if (n >= 24 && n <= 29) return "R8";
    return "R6";
  endfunction

  // One counted event per call, alternating inputs; returns at the next
  // falling edge, after the rising edge that acted on it.
  task automatic edgeStep();
    if (nextA) begin clkA = 1'b1; clkB = 1'b0; end
    else       begin clkA = 1'b0; clkB = 1'b1; end
    nextA = !nextA;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    clkA = 1'b0; clkB = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseA();
    clkA = 1'b1; clkB = 1'b0; @(negedge clk);
    clkA = 1'b0; @(negedge clk);
  endtask

  task automatic pulseB();
    clkB = 1'b1; clkA = 1'b0; @(negedge clk);
    clkB = 1'b0; @(negedge clk);
  endtask

  // Load codes with one event, then count events to the first rise and the
  // following fall of each output and compare with the expected ratios.
  task automatic runCode(int n5, int n4, longint evts, bit chk4);
    longint riseAt[4];
    longint fallAt[4];
    longint ratio[4];
    logic   prevS[4];
    logic   cur[4];
    string  tag[4];
    prog5 = n5[4:0];
    if (chk4) prog4 = n4[3:0];
    edgeStep();
    check("R9 load q", q5, 0);
    check("R9 load tap", t5, 0);
    if (chk4) check("R9 load q small", q4, 0);
    ratio[0] = ratioQ(n5);  ratio[1] = ratioT5(n5);
    ratio[2] = ratioQ(n4);  ratio[3] = ratioT4(n4);
    tag[0] = (n5 < 2) ? "R4 q" : "R5 q";
    tag[1] = {tagT5(n5), " tap"};
    tag[2] = (n4 < 2) ? "R4 q small" : "R5 q small";
    tag[3] = "R10 tap small";
    for (int j = 0; j < 4; j++) begin
      riseAt[j] = 0; fallAt[j] = 0; prevS[j] = 1'b0;
    end
    for (longint k = 1; k <= evts; k++) begin
      edgeStep();
      cur[0] = q5; cur[1] = t5; cur[2] = q4; cur[3] = t4;
      for (int j = 0; j < 4; j++) begin
        if (cur[j] && !prevS[j] && riseAt[j] == 0) riseAt[j] = k;
        if (!cur[j] && prevS[j] && riseAt[j] != 0 && fallAt[j] == 0) fallAt[j] = k;
        prevS[j] = cur[j];
      end
    end
    for (int j = 0; j < 4; j++) begin
      if (j < 2 || chk4) begin
        check({tag[j], " rise"}, riseAt[j],
              (ratio[j] != 0 && ratio[j] / 2 <= evts) ? ratio[j] / 2 : 0);
        check({tag[j], " fall"}, fallAt[j],
              (ratio[j] != 0 && ratio[j] <= evts) ? ratio[j] : 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset q", q5, 0);
    check("R1 reset tap", t5, 0);
    check("R1 reset q small", q4, 0);
    clearN = 1'b1;
    idle(4);

    // Inhibit codes
    runCode(0, 0, 600, 1'b1);
    runCode(1, 1, 600, 1'b1);

    // Single-input events and gating, code 2 (ratio 4)
    idle(1);
    prog5 = 5'd2; prog4 = 4'd2;
    pulseA();
    check("R9 load q", q5, 0);
    pulseB();
    check("R2 count1 q", q5, 0);
    pulseA();
    check("R2 count2 q", q5, 1);
    clkA = 1'b1; clkB = 1'b1; @(negedge clk);
    check("R3 both rise", q5, 1);
    repeat (2) @(negedge clk);
    clkB = 1'b0; @(negedge clk);
    check("R3 A held high", q5, 1);
    clkB = 1'b1; @(negedge clk);
    check("R3 B rise while A high", q5, 1);
    clkA = 1'b0; @(negedge clk);
    check("R3 B held high", q5, 1);
    idle(1);
    pulseB();
    check("R3 count3 q", q5, 1);
    pulseA();
    check("R3 count4 q", q5, 0);

    // Ratio sweep on both builds
    idle(1);
    runCode(0, 0, 8, 1'b1);
    for (int n = 2; n <= 15; n++) begin
      longint evts = ((64'(1) << n) > 1024) ? (64'(1) << n) : 1024;
      runCode(n, n, evts, 1'b1);
    end
    for (int n = 16; n <= 31; n++) runCode(n, 15, 1024, 1'b0);

    // Program change waits for an event
    idle(1);
    prog5 = 5'd2; prog4 = 4'd2;
    pulseA(); pulseB(); pulseA();
    check("R9 running q", q5, 1);
    prog5 = 5'd3;
    idle(3);
    check("R9 pending no effect", q5, 1);
    pulseB();
    check("R9 restart q", q5, 0);
    pulseA(); pulseB(); pulseA();
    check("R9 count3 q", q5, 0);
    pulseB();
    check("R9 count4 q", q5, 1);

    // Clear mid-run
    clearN = 1'b0;
    #1;
    check("R1 async q", q5, 0);
    check("R1 async q small", q4, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      pulseA();
      check("R1 held q", q5, 0);
    end
    clearN = 1'b1;
    idle(4);
    check("R1 released q", q5, 0);
    pulseB();
    check("R1 reload q", q5, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule